// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is a decade counter split into two storage sections: a one-bit divide-by-two stage and a three-bit divide-by-five stage whose code reads as a plain binary number from 0 to 4. Each section has its own count-enable. Everything updates on the rising edge of one clock. A mode input picks which section drives the other, and the mode can change on any cycle.

With the mode low, the counter runs as a BCD counter. The two-stage stage is the least significant digit bit. Each time it falls from 1 to 0, the five-stage section advances on the same edge. Read as `{q_qui, q_bin}`, the value runs 0 to 9. With the mode high, the order is reversed. Each time the five-stage section wraps from 4 to 0, it toggles the two-stage bit. This gives a symmetric divide-by-ten on `q_bin`.

Reset drives all four count bits high. From that state, the five-stage section holds code 7, which is out of range. Its next advance takes it to 0. A registered terminal-count strobe marks the end of each decade in either mode.

Top module: `biquin_decade_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge sets `q_bin` to 1, sets `q_qui` to 3'b111 and sets `tc` to 0, whatever the enables are.
- R2: The two-stage bit inverts on every edge where it steps. An edge with no step leaves it unchanged.
- R3: The five-stage code moves through 0,1,2,3,4,0 on successive steps. An edge with no step leaves it unchanged.
- R4: From any code 5 to 7, the next step of the five-stage section loads 0. This step does not produce a carry into the two-stage bit.
- R5: With `mode`=0 (BCD), the two-stage bit steps when `en_bin` is high. The five-stage section steps when `en_qui` is high, or on the same edge at which the two-stage bit falls from 1 to 0. After reset, with only `en_bin` held high, `{q_qui,q_bin}` reads 0,1,...,9,0 on successive edges.
- R6: With `mode`=1 (symmetric), the five-stage section steps when `en_qui` is high. The two-stage bit steps when `en_bin` is high, or on the same edge at which the five-stage code wraps from 4 to 0. With only `en_qui` high, `q_bin` is high for exactly 5 of every 10 edges.
- R7: With `mode`=0, `tc` is high for the single cycle after an edge that moved the count from 9 (`q_qui`=4, `q_bin`=1) to 0 through the carry from the two-stage bit. Otherwise it is low.
- R8: With `mode`=1, `tc` is high for the single cycle after an edge at which `q_bin` fell from 1 to 0. Otherwise it is low.
- R9: A change of `mode` does not alter the stored bits. The next step follows the chaining rule of the new mode.
- R10: With both enables low, no bit changes and `tc` reads 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, drives count bits high |
| mode | input | 1 | 0: BCD chaining, 1: symmetric divide-by-ten chaining |
| en_bin | input | 1 | Count-enable of the two-stage bit |
| en_qui | input | 1 | Count-enable of the five-stage section |
| q_bin | output | 1 | Two-stage bit (BCD weight 1) |
| q_qui | output | 3 | Five-stage code (BCD weights 2, 4, 8 when read with q_bin) |
| tc | output | 1 | One-cycle terminal-count strobe |

## Verification
The hardest state to reach is the out-of-range five-stage code. No count sequence ever produces it, so it exists only right after reset. For that reason, each scenario starts from a fresh reset and then takes its first step through a different path. One path is the binary carry in BCD mode. The other is a direct `en_qui` step in symmetric mode. In both, the bench checks that 7 goes to 0 with no carry. The other case that is hard to hit is a mode change mid-count. The bench switches mode exactly when the two-stage bit sits at 1. The same falling edge then steps the five-stage section in one mode and leaves it alone in the other.

// File: rtl/biquin_pkg.sv
// Package: shared types of the bi-quinary decade counter.
// Assumes: a one-bit mode input is cast to chain_mode_e at the top.
package biquin_pkg;

    // Order in which the two sections are chained.
    typedef enum logic {
        CHAIN_BCD = 1'b0,   // two-stage bit drives the five-stage section
        CHAIN_SYM = 1'b1    // five-stage wrap drives the two-stage bit
    } chain_mode_e;

endpackage

// File: rtl/bq_binary_stage.sv
// Module: bq_binary_stage
// A single divide-by-two storage bit. It inverts on each edge where step
// is high and holds otherwise. Reset loads 1.
// Assumes: step is already qualified by the chain controller.
module bq_binary_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic q
);

    // Storage bit: reset to one, invert on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b1;
        end else if (step) begin
            q <= ~q;
        end
    end

    AST_BIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q != $past(q))) else $error("binary stage missed a toggle"); // R2

    AST_BIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && rst_n) |=> $stable(q)) else $error("binary stage moved without step"); // R10

endmodule

// File: rtl/bq_quinary_stage.sv
// Module: bq_quinary_stage
// A divide-by-MOD counter with a binary-coded state. On step it advances
// 0..MOD-1 and wraps to 0. Any code at or above MOD-1 loads 0, so codes
// that are out of range leave the sequence after one step. Reset loads all
// ones. at_last flags the code MOD-1, from which a step produces a carry.
// Assumes: MOD >= 2 and step is qualified by the chain controller.
module bq_quinary_stage #(
    parameter int MOD = 5,
    localparam int W  = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] q,
    output logic         at_last
);

    localparam logic [W-1:0] LAST_CODE = W'(MOD - 1);

    // Flag for the code from which a step wraps with a carry.
    always_comb begin
        at_last = (q == LAST_CODE);
    end

    // State register: all ones on reset, advance or recover to zero on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else if (step) begin
            if (q >= LAST_CODE) begin
                q <= '0;
            end else begin
                q <= q + 1'b1;
            end
        end
    end

    AST_QUI_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (q < W'(MOD))) else $error("quinary code out of range after step"); // R4

    AST_QUI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(rst_n) && (q < LAST_CODE)) |=> (q == $past(q) + 1'b1))
        else $error("quinary code skipped"); // R3

    AST_QUI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && rst_n) |=> $stable(q)) else $error("quinary code moved without step"); // R10

endmodule

// File: rtl/bq_chain_ctrl.sv
// Module: bq_chain_ctrl
// Builds the per-edge step strobes of both sections from the external
// enables and the cascade carry. The chain order follows the mode. The
// cascade carry acts on the same edge that produces it. Also registers
// the terminal-count strobe.
// Assumes: mode may change on any cycle and is combinational here.
module bq_chain_ctrl
    import biquin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chain_mode_e mode,
    input  logic        en_bin,
    input  logic        en_qui,
    input  logic        bin_q,
    input  logic        qui_last,
    output logic        bin_step,
    output logic        qui_step,
    output logic        tc
);

    logic bin_fall;
    logic qui_wrap;
    logic tc_next;

    // Step strobes and cascade carry for the selected chaining order.
    always_comb begin
        bin_fall = 1'b0;
        qui_wrap = 1'b0;
        tc_next  = 1'b0;
        if (mode == CHAIN_BCD) begin
            bin_step = en_bin;
            bin_fall = bin_step & bin_q;
            qui_step = en_qui | bin_fall;
            tc_next  = bin_fall & qui_last;
        end else begin
            qui_step = en_qui;
            qui_wrap = qui_step & qui_last;
            bin_step = en_bin | qui_wrap;
            bin_fall = bin_step & bin_q;
            tc_next  = bin_fall;
        end
    end

    // Terminal-count register: cleared by reset, one cycle per decade end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else begin
            tc <= tc_next;
        end
    end

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc) else $error("terminal count held longer than one cycle"); // R7

    AST_SYM_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CHAIN_SYM && qui_step && qui_last) |-> bin_step)
        else $error("symmetric mode lost the quinary carry"); // R6

    AST_BCD_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CHAIN_BCD && bin_step && bin_q) |-> qui_step)
        else $error("BCD mode lost the binary carry"); // R5

endmodule

// File: rtl/biquin_decade_counter.sv
// Module: biquin_decade_counter (top)
// A decade counter built from a divide-by-two bit and a divide-by-QUI_MOD
// section. The mode input chooses the chain order: BCD readout or a
// symmetric divide-by-ten on q_bin. Reset is synchronous and active-low,
// and it drives all count bits high.
// Assumes: a single clock domain. Inputs are synchronous to clk.
module biquin_decade_counter
    import biquin_pkg::*;
#(
    parameter int QUI_MOD = 5,
    localparam int QUI_W  = (QUI_MOD > 2) ? $clog2(QUI_MOD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             en_bin,
    input  logic             en_qui,
    output logic             q_bin,
    output logic [QUI_W-1:0] q_qui,
    output logic             tc
);

    chain_mode_e mode_e;
    logic        bin_step;
    logic        qui_step;
    logic        qui_last;

    // Cast the raw mode pin to the shared enum.
    always_comb begin
        mode_e = chain_mode_e'(mode);
    end

    bq_chain_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .en_bin   (en_bin),
        .en_qui   (en_qui),
        .bin_q    (q_bin),
        .qui_last (qui_last),
        .bin_step (bin_step),
        .qui_step (qui_step),
        .tc       (tc)
    );

    bq_binary_stage u_bin (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (bin_step),
        .q     (q_bin)
    );

    bq_quinary_stage #(.MOD(QUI_MOD)) u_qui (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (qui_step),
        .q       (q_qui),
        .at_last (qui_last)
    );

    // Track a reset edge so that the state after it can be checked.
    logic rst_seen;
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen) begin
            AST_RESET_ONES: assert (q_bin && (q_qui == '1) && !tc)
                else $error("reset did not set count bits high"); // R1
        end
    end

endmodule

// File: tb/biquin_decade_counter_tb_top.sv
// Directed bench of the bi-quinary decade counter. Each scenario task drives
// its stimulus and checks its own results.
module biquin_decade_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       en_bin = 1'b0;
    logic       en_qui = 1'b0;
    logic       q_bin;
    logic [2:0] q_qui;
    logic       tc;

    int n_chk = 0;
    int n_bad = 0;

    biquin_decade_counter dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .en_bin (en_bin),
        .en_qui (en_qui),
        .q_bin  (q_bin),
        .q_qui  (q_qui),
        .tc     (tc)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // One rising edge, then settle 1 ns past it before sampling or driving.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        rst_n  = 1'b0;
        mode   = m;
        en_bin = 1'b1;
        en_qui = 1'b1;
        tick();
        tick();
        chk("R1", "q_bin after reset", q_bin, 1);
        chk("R1", "q_qui after reset", q_qui, 7);
        chk("R1", "tc after reset", tc, 0);
        en_bin = 1'b0;
        en_qui = 1'b0;
        rst_n  = 1'b1;
    endtask

    // BCD mode, binary enable only: 0..9 then wrap, tc after 9 -> 0.
    task automatic t_bcd_count();
        do_reset(1'b0);
        en_bin = 1'b1;
        for (int i = 1; i <= 22; i++) begin
            tick();
            chk("R5", "BCD value", {q_qui, q_bin}, (i - 1) % 10);
            chk("R7", "BCD tc", tc, ((i > 1) && ((i - 1) % 10 == 0)) ? 1 : 0);
        end
        en_bin = 1'b0;
    endtask

    // Symmetric mode, quinary enable only: divide-by-ten with 50% duty.
    task automatic t_sym_divide();
        int highs;
        do_reset(1'b1);
        en_qui = 1'b1;
        tick();
        chk("R4", "7 -> 0 no carry, q_qui", q_qui, 0);
        chk("R4", "7 -> 0 no carry, q_bin", q_bin, 1);
        highs = 0;
        for (int i = 2; i <= 21; i++) begin
            tick();
            chk("R3", "quinary code", q_qui, (i - 1) % 5);
            chk("R6", "symmetric q_bin", q_bin, (((i - 1) / 5) % 2 == 0) ? 1 : 0);
            chk("R8", "symmetric tc", tc, ((i - 1) % 10 == 5) ? 1 : 0);
            if (i >= 12) highs += q_bin;
        end
        chk("R6", "high count over 10 edges", highs, 5);
        en_qui = 1'b0;
    endtask

    // Both enables low: all state holds, tc stays low.
    task automatic t_hold();
        do_reset(1'b0);
        en_bin = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        en_bin = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10", "held value", {q_qui, q_bin}, 3);
            chk("R10", "held tc", tc, 0);
        end
    endtask

    // Independent enables: a direct quinary step in BCD mode, a direct binary step in symmetric mode.
    task automatic t_independent();
        do_reset(1'b0);
        en_qui = 1'b1;
        tick();
        chk("R4", "BCD en_qui from 7, q_qui", q_qui, 0);
        chk("R5", "BCD en_qui keeps q_bin", q_bin, 1);
        tick();
        chk("R5", "BCD en_qui step again", {q_qui, q_bin}, 3);
        en_qui = 1'b0;
        mode   = 1'b1;
        en_bin = 1'b1;
        tick();
        chk("R2", "symmetric direct toggle", q_bin, 0);
        chk("R8", "tc on direct fall", tc, 1);
        chk("R6", "quinary untouched by bin fall", q_qui, 1);
        tick();
        chk("R2", "toggle back", q_bin, 1);
        chk("R8", "no tc on rise", tc, 0);
        en_bin = 1'b0;
    endtask

    // Change mode mid-count with q_bin high: the falling edge must follow the new rule.
    task automatic t_mode_switch();
        do_reset(1'b0);
        en_bin = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk("R9", "count before switch", {q_qui, q_bin}, 3);
        mode = 1'b1;
        tick();
        chk("R9", "after switch q_qui", q_qui, 1);
        chk("R9", "after switch q_bin", q_bin, 0);
        chk("R8", "tc on fall after switch", tc, 1);
        mode = 1'b0;
        tick();
        chk("R9", "back to BCD", {q_qui, q_bin}, 3);
        tick();
        chk("R9", "BCD carry resumes", {q_qui, q_bin}, 4);
        en_bin = 1'b0;
    endtask

    // Reset in mid-count with enables high wins over counting.
    task automatic t_reset_priority();
        do_reset(1'b1);
        en_qui = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b0;
        tick();
        chk("R1", "mid-count reset q_qui", q_qui, 7);
        chk("R1", "mid-count reset q_bin", q_bin, 1);
        rst_n  = 1'b1;
        en_qui = 1'b0;
    endtask

    initial begin
        #2;
        t_bcd_count();
        t_sym_divide();
        t_hold();
        t_independent();
        t_mode_switch();
        t_reset_priority();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule